// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words of nine bits enter on the write clock and leave on the read clock. Both enables are active low. A master reset chooses one of two output timings, and that choice holds until the next master reset.

In standard timing, every word, including the first one, stays inside the buffer until the reader asks for it. In fall-through timing, the oldest stored word is loaded onto the output by itself. A read then consumes it and brings the next word forward. Because of this, two buffers in fall-through timing can be chained output to input without glue logic.

The block has two combined status outputs. Their meaning depends on the timing mode. It also has three level flags that behave the same in both modes. A partial reset empties the buffer but keeps the timing mode. A rewind input sends the reader back to the first memory location. The two level thresholds are supplied on input ports.

Top module: `dual_mode_fifo`

## Requirements
- R1: After a master or a partial reset, `rdData` is 0, `emptyOrNotReady` is 1, `fullOrNotReady` is 0, `halfFull` is 0, `almostEmpty` is 1, and `almostFull` is 0 whenever `afOffset` < DEPTH.
- R2: `modeSel` is sampled at every `rdClk` edge while `mrstN` is low: 1 selects fall-through timing and 0 selects standard timing. The choice is kept through partial resets and later changes of `modeSel`, until the next master reset.
- R3: In standard timing, a word written into an empty buffer does not reach `rdData` until a read. A read is `rdEnN` low at a rising `rdClk` edge while the buffer is not empty. Each read loads the oldest unread word, and `rdData` holds its value between reads.
- R4: In fall-through timing, the oldest word appears on `rdData` within four `rdClk` edges of being written, with no read. `rdEnN` low at an edge consumes it and presents the next word. `emptyOrNotReady` is 1 exactly while no valid word is presented.
- R5: In standard timing, `emptyOrNotReady` is 1 exactly when no unread word is stored, as seen from the read clock domain.
- R6: `fullOrNotReady` is 1 when DEPTH words occupy memory. Writes attempted while it is 1 are dropped and leave the stored data and its order unchanged.
- R7: In standard timing, a read attempted while empty leaves `rdData` and the read position unchanged. A later write is then read back correctly.
- R8: `halfFull` is 1 when the number of words held in memory, as counted in the write domain, is greater than DEPTH/2.
- R9: `almostEmpty` is 1 when the read-side word count is at or below `aeOffset`. In fall-through timing, that count includes the word on the output.
- R10: `almostFull` is 1 when DEPTH minus the write-side word count is at or below `afOffset`.
- R11: `rtN` low at a rising `rdClk` edge moves the read position to memory location 0 and overrides any read at that edge. After this, the stored words are read again from location 0. In standard timing, `rdData` is unchanged by the rewind itself.
- R12: A partial reset (`prstN` low at edges of both clocks) discards all stored words and returns both positions to location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, sampled by both clocks |
| prstN | input | 1 | Partial reset, active low, sampled by both clocks |
| modeSel | input | 1 | Timing select, sampled during master reset (1 = fall-through) |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | DW (9) | Write data |
| rdEnN | input | 1 | Read enable, active low |
| rtN | input | 1 | Rewind to location 0, active low |
| aeOffset | input | $clog2(DEPTH)+1 | Almost-empty threshold in words |
| afOffset | input | $clog2(DEPTH)+1 | Almost-full threshold in free words |
| rdData | output | DW (9) | Read data |
| emptyOrNotReady | output | 1 | Empty (standard) or no word presented (fall-through) |
| fullOrNotReady | output | 1 | Full, no write accepted |
| halfFull | output | 1 | More than half of the memory occupied |
| almostEmpty | output | 1 | Read-side count at or below aeOffset |
| almostFull | output | 1 | Free space at or below afOffset |

## Verification
Errors in the pointers show up at the ports as words that are missing, repeated or out of order. In one case, a location is rewritten while full, and a later read then returns the wrong value. The bench shows this by comparing every word read against a queue of the words written. These errors appear on the first read after the fault, or within one buffer depth when the fault is in the wrap bit. Errors in the mode register appear within four read clocks of a write, because the word either shows up or fails to show up without a read. Errors in the flags are caught at the exact fill levels where each flag must switch.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  // Strobes handed from control to datapath each clock.
  typedef struct packed {
    logic wrFire;  // store wrData at wrAddr on this wrClk edge
    logic rdFire;  // load memory word at rdAddr into rdData on this rdClk edge
  } dmfStrobe_t;

endpackage

// File: rtl/dmf_ptr_sync.sv
module dmf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] grayOut
);

  logic [W-1:0] stageA;
  logic [W-1:0] stageB;

  always_ff @(posedge clk) begin
    if (clr) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      stageA <= grayIn;
      stageB <= stageA;
    end
  end

  assign grayOut = stageB;

endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import dmf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          modeSel,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          rtN,
  input  logic [CW-1:0] aeOffset,
  input  logic [CW-1:0] afOffset,
  output dmfStrobe_t    strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fwftMode,
  output logic          emptyFlag,
  output logic          fullFlag,
  output logic          halfFlag,
  output logic          aeFlag,
  output logic          afFlag
);

  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] FULLN = CW'(DEPTH);
  localparam logic [CW-1:0] HALFN = CW'(DEPTH / 2);

  function automatic logic [CW-1:0] toGray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] fromGray(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rstAny;
  assign rstAny = !mrstN || !prstN;

  // ---------------- write domain ----------------
  logic [CW-1:0] wrBin, wrGray, wrNext;
  logic [CW-1:0] rdGraySync, rdBinSync, wrLevel;
  logic          wrFire;

  dmf_ptr_sync #(.W(CW)) u_rdToWr (
    .clk    (wrClk),
    .clr    (rstAny),
    .grayIn (rdGray),
    .grayOut(rdGraySync)
  );

  assign rdBinSync = fromGray(rdGraySync);
  assign wrLevel   = wrBin - rdBinSync;
  assign fullFlag  = (wrLevel == FULLN);
  assign wrFire    = !wrEnN && !fullFlag && !rstAny;
  assign wrNext    = wrBin + ONE;

  always_ff @(posedge wrClk) begin
    if (rstAny) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrFire) begin
      wrBin  <= wrNext;
      wrGray <= toGray(wrNext);
    end
  end

  assign halfFlag = (wrLevel > HALFN);
  assign afFlag   = ((FULLN - wrLevel) <= afOffset);

  // ---------------- read domain ----------------
  logic [CW-1:0] rdBin, rdGray, rdNext;
  logic [CW-1:0] wrGraySync, wrBinSync, memLevel;
  logic [CW:0]   rdLevel;
  logic          outValid, memEmpty, rewind, wantFetch, rdFire;

  dmf_ptr_sync #(.W(CW)) u_wrToRd (
    .clk    (rdClk),
    .clr    (rstAny),
    .grayIn (wrGray),
    .grayOut(wrGraySync)
  );

  always_ff @(posedge rdClk) begin
    if (!mrstN) fwftMode <= modeSel;
  end

  assign wrBinSync = fromGray(wrGraySync);
  assign memEmpty  = (wrBinSync == rdBin);
  assign memLevel  = wrBinSync - rdBin;
  assign rewind    = !rtN;
  assign wantFetch = fwftMode ? (!outValid || !rdEnN) : !rdEnN;
  assign rdFire    = !rstAny && !rewind && wantFetch && !memEmpty;
  assign rdNext    = rdBin + ONE;

  always_ff @(posedge rdClk) begin
    if (rstAny || rewind) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdFire) begin
        rdBin  <= rdNext;
        rdGray <= toGray(rdNext);
      end
      if (fwftMode) begin
        if (rdFire)      outValid <= 1'b1;
        else if (!rdEnN) outValid <= 1'b0;
      end
    end
  end

  assign rdLevel   = {1'b0, memLevel} + {{CW{1'b0}}, (fwftMode && outValid)};
  assign aeFlag    = (rdLevel <= {1'b0, aeOffset});
  assign emptyFlag = fwftMode ? !outValid : memEmpty;

  assign strobes.wrFire = wrFire;
  assign strobes.rdFire = rdFire;
  assign wrAddr         = wrBin[AW-1:0];
  assign rdAddr         = rdBin[AW-1:0];

endmodule

// File: rtl/dmf_datapath.sv
module dmf_datapath
  import dmf_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          clr,
  input  dmfStrobe_t    strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrFire) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (clr)                 rdData <= '0;
    else if (strobes.rdFire) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          modeSel,
  input  logic          wrEnN,
  input  logic [DW-1:0] wrData,
  input  logic          rdEnN,
  input  logic          rtN,
  input  logic [CW-1:0] aeOffset,
  input  logic [CW-1:0] afOffset,
  output logic [DW-1:0] rdData,
  output logic          emptyOrNotReady,
  output logic          fullOrNotReady,
  output logic          halfFull,
  output logic          almostEmpty,
  output logic          almostFull
);

  dmfStrobe_t    strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic          fwftMode;

  dmf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .mrstN    (mrstN),
    .prstN    (prstN),
    .modeSel  (modeSel),
    .wrEnN    (wrEnN),
    .rdEnN    (rdEnN),
    .rtN      (rtN),
    .aeOffset (aeOffset),
    .afOffset (afOffset),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .fwftMode (fwftMode),
    .emptyFlag(emptyOrNotReady),
    .fullFlag (fullOrNotReady),
    .halfFlag (halfFull),
    .aeFlag   (almostEmpty),
    .afFlag   (almostFull)
  );

  dmf_datapath #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .clr    (!mrstN || !prstN),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: rtl/dual_mode_fifo_chk.sv
module dual_mode_fifo_chk #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          mrstN,
  input logic          prstN,
  input logic          wrEnN,
  input logic          rdEnN,
  input logic          rtN,
  input logic          fullOrNotReady,
  input logic          halfFull,
  input logic          emptyOrNotReady,
  input logic          fwftMode,
  input logic [AW-1:0] wrAddr,
  input logic [AW-1:0] rdAddr,
  input logic [DW-1:0] rdData
);

  p_no_overflow_r6: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    (fullOrNotReady && !wrEnN) |=> $stable(wrAddr));

  p_full_is_half_r8: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    fullOrNotReady |-> halfFull);

  p_no_underflow_r7: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (!fwftMode && emptyOrNotReady && !rdEnN && rtN) |=> ($stable(rdData) && $stable(rdAddr)));

  p_idle_hold_r3: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (!fwftMode && rdEnN) |=> $stable(rdData));

  p_head_hold_r4: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (fwftMode && !emptyOrNotReady && rdEnN && rtN) |=> ($stable(rdData) && !emptyOrNotReady));

  p_rewind_r11: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    !rtN |=> (rdAddr == '0));

endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wrClk          (wrClk),
  .rdClk          (rdClk),
  .mrstN          (mrstN),
  .prstN          (prstN),
  .wrEnN          (wrEnN),
  .rdEnN          (rdEnN),
  .rtN            (rtN),
  .fullOrNotReady (fullOrNotReady),
  .halfFull       (halfFull),
  .emptyOrNotReady(emptyOrNotReady),
  .fwftMode       (fwftMode),
  .wrAddr         (wrAddr),
  .rdAddr         (rdAddr),
  .rdData         (rdData)
);

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 16;
  localparam int DW         = 9;
  localparam int CW         = $clog2(DEPTH) + 1;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          mrstN = 1'b0, prstN = 1'b1, modeSel = 1'b0;
  logic          wrEnN = 1'b1, rdEnN = 1'b1, rtN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [CW-1:0] aeOffset = CW'(2), afOffset = CW'(3);
  logic [DW-1:0] rdData;
  logic          emptyOrNotReady, fullOrNotReady, halfFull, almostEmpty, almostFull;

  dual_mode_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wrEnN(wrEnN), .wrData(wrData), .rdEnN(rdEnN), .rtN(rtN),
    .aeOffset(aeOffset), .afOffset(afOffset), .rdData(rdData),
    .emptyOrNotReady(emptyOrNotReady), .fullOrNotReady(fullOrNotReady),
    .halfFull(halfFull), .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  always #(CLK_PERIOD / 2) wrClk = ~wrClk;
  always #(RD_PERIOD / 2)  rdClk = ~rdClk;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [DW-1:0] expQ[$];

  task automatic chk(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic masterReset(input bit mode);
    @(negedge rdClk);
    mrstN = 1'b0; modeSel = mode;
    repeat (3) @(negedge wrClk);
    repeat (3) @(negedge rdClk);
    mrstN = 1'b1; modeSel = !mode;
    expQ.delete();
  endtask

  task automatic partialReset();
    @(negedge rdClk);
    prstN = 1'b0;
    repeat (3) @(negedge wrClk);
    repeat (3) @(negedge rdClk);
    prstN = 1'b1;
    expQ.delete();
  endtask

  // driver: pushes the expected word into the scoreboard when accepted
  task automatic pushWord(input logic [DW-1:0] d, input bit accept);
    @(negedge wrClk);
    wrEnN = 1'b0; wrData = d;
    @(negedge wrClk);
    wrEnN = 1'b1;
    if (accept) expQ.push_back(d);
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (2) @(negedge wrClk);
  endtask

  // monitor for standard timing: read, then pop and compare
  task automatic stdRead(input string tag);
    logic [DW-1:0] e;
    @(negedge rdClk);
    rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1;
    e = expQ.pop_front();
    chk(tag, int'(rdData), int'(e));
  endtask

  // monitor for fall-through timing: compare presented head, then consume
  task automatic fwftRead(input string tag);
    logic [DW-1:0] e;
    @(negedge rdClk);
    e = expQ.pop_front();
    chk(tag, int'(rdData), int'(e));
    rdEnN = 1'b0;
    @(negedge rdClk);
    rdEnN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // ---- reset state (R1) ----
    masterReset(1'b0);
    @(negedge rdClk);
    chk("R1 empty", int'(emptyOrNotReady), 1);
    chk("R1 full", int'(fullOrNotReady), 0);
    chk("R1 half", int'(halfFull), 0);
    chk("R1 almostEmpty", int'(almostEmpty), 1);
    chk("R1 almostFull", int'(almostFull), 0);
    chk("R1 rdData", int'(rdData), 0);

    // ---- standard timing (R3, R5, R9, R7) ----
    pushWord(9'h1A1, 1); pushWord(9'h0B2, 1); pushWord(9'h0C3, 1);
    settle();
    chk("R5 not empty", int'(emptyOrNotReady), 0);
    chk("R3 no read no data", int'(rdData), 0);
    chk("R9 count3 above", int'(almostEmpty), 0);
    stdRead("R3 first");
    chk("R9 count2 at", int'(almostEmpty), 1);
    stdRead("R3 second");
    stdRead("R3 third");
    chk("R5 empty again", int'(emptyOrNotReady), 1);
    @(negedge rdClk); rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1;
    chk("R7 empty read holds", int'(rdData), 'h0C3);
    pushWord(9'h055, 1);
    settle();
    stdRead("R7 after underflow");

    // ---- fill, overflow, order (R8, R10, R6) ----
    masterReset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(DW'(i * 37 + 5), 1);
      if (i == 7)  chk("R8 at half", int'(halfFull), 0);
      if (i == 8)  chk("R8 above half", int'(halfFull), 1);
      if (i == 11) chk("R10 free4", int'(almostFull), 0);
      if (i == 12) chk("R10 free3", int'(almostFull), 1);
    end
    chk("R6 full", int'(fullOrNotReady), 1);
    pushWord(9'h1FF, 0);
    chk("R6 still full", int'(fullOrNotReady), 1);
    settle();
    for (int i = 0; i < DEPTH; i++) stdRead("R6 order after overflow");
    chk("R5 drained", int'(emptyOrNotReady), 1);
    settle();
    chk("R6 full clears", int'(fullOrNotReady), 0);
    chk("R8 half clears", int'(halfFull), 0);

    // ---- retransmit in standard timing (R11) ----
    masterReset(1'b0);
    pushWord(9'h101, 1); pushWord(9'h102, 1); pushWord(9'h103, 1);
    settle();
    stdRead("R11 pre a"); stdRead("R11 pre b");
    @(negedge rdClk); rtN = 1'b0; rdEnN = 1'b0;
    @(negedge rdClk); rtN = 1'b1; rdEnN = 1'b1;
    chk("R11 rewind keeps data", int'(rdData), 'h102);
    expQ.delete();
    expQ.push_back(9'h101); expQ.push_back(9'h102); expQ.push_back(9'h103);
    settle();
    stdRead("R11 reread a"); stdRead("R11 reread b"); stdRead("R11 reread c");

    // ---- fall-through timing (R2, R4, R9) ----
    masterReset(1'b1);
    chk("R1 fwft notready", int'(emptyOrNotReady), 1);
    pushWord(9'h0AA, 1);
    repeat (4) @(negedge rdClk);
    chk("R4 head appears", int'(rdData), 'h0AA);
    chk("R4 ready", int'(emptyOrNotReady), 0);
    pushWord(9'h0BB, 1); pushWord(9'h0CC, 1);
    settle();
    chk("R9 fwft count3", int'(almostEmpty), 0);
    fwftRead("R4 first"); fwftRead("R4 second"); fwftRead("R4 third");
    @(negedge rdClk);
    chk("R4 notready after drain", int'(emptyOrNotReady), 1);

    // ---- partial reset keeps mode (R12, R2) ----
    pushWord(9'h123, 1);
    settle();
    modeSel = 1'b0;
    partialReset();
    @(negedge rdClk);
    chk("R12 empty", int'(emptyOrNotReady), 1);
    chk("R12 rdData", int'(rdData), 0);
    chk("R12 half", int'(halfFull), 0);
    pushWord(9'h0F0, 1);
    settle();
    chk("R2 mode kept", int'(rdData), 'h0F0);
    chk("R2 ready kept", int'(emptyOrNotReady), 0);

    masterReset(1'b0);
    pushWord(9'h077, 1);
    settle();
    chk("R2 standard again data", int'(rdData), 0);
    chk("R2 standard again flag", int'(emptyOrNotReady), 0);
    stdRead("R2 standard read");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule